// File: doc/BRIEF.md
# Latched Status Flag Interrupt Controller

This block turns raw, possibly brief status conditions into sticky flag bits that a host can read over a byte-addressed register port. The conditions are receive loss of signal, transmit loss of signal and transmit fault for each lane, plus module monitor alarm and warning flags. Each flag sets while its condition is high. It then stays set until the host reads the byte that holds it. That read returns the value as it stood and clears the byte in the same clock.

Unmasked flags are merged into one registered, active-low interrupt pin with open-drain semantics. A copy of the pin level can be read in the status byte. After reset the block holds a data-not-ready bit for a fixed number of clocks, and the interrupt is held off during that time. When the bit clears, a sticky reset-done flag is posted. This flag raises the interrupt without any action from the host.

Read port rules: `rd_stb` is a single-cycle request and needs no back-pressure. `rd_data` is loaded on the clock edge that samples the strobe and holds until the next strobe.

Top module: `stat_irq_ctrl`

## Requirements
- R1: A flag bit sets on any clock edge where its condition input is high. It stays set after the condition returns low until its byte is read, even for a one-cycle condition pulse.
- R2: Byte layout: address 3 holds receive LOS lanes 0..3 in bits 0..3 and transmit LOS lanes 0..3 in bits 4..7. Address 4 holds transmit fault lanes 0..3 in bits 0..3, with the upper bits reading 0. Address 5 holds monitor flags 0..7 in bits 0..7. Any other address except 2 reads 0x00.
- R3: `rd_data` holds the byte as it was before the read, one clock after the strobe. That read clears every flag of that byte and no flag of any other byte.
- R4: If a condition is high on the clock edge of the clearing read, its flag is still set afterwards. A later read reports it again.
- R5: A mask bit of 1 keeps its flag from asserting `irq_n`. The flag still latches and still reads back.
- R6: `irq_n` goes low on the second clock edge after an unmasked condition is sampled. It returns high within two clocks after the read that clears the last unmasked flag.
- R7: Address 2 holds three bits: data-not-ready in bit 0, the current `irq_n` pin level in bit 1, and the reset-done flag in bit 2. Its other bits read 0. A read of address 2 clears the reset-done flag.
- R8: Data-not-ready is 1 from reset for INIT_CYCLES clocks and then drops to 0 for good. While it is 1, `irq_n` stays high. When it drops, the reset-done flag sets and drives `irq_n` low with no host action.
- R9: During and right after reset, `irq_n` is 1, `rd_data` is 0x00 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_los_cond | input | LANES | Raw receive loss-of-signal per lane |
| tx_los_cond | input | LANES | Raw transmit loss-of-signal per lane |
| tx_flt_cond | input | LANES | Raw transmit fault per lane |
| mon_cond | input | MON_W | Raw monitor alarm/warning conditions |
| rx_los_mask | input | LANES | Interrupt mask, receive LOS |
| tx_los_mask | input | LANES | Interrupt mask, transmit LOS |
| tx_flt_mask | input | LANES | Interrupt mask, transmit fault |
| mon_mask | input | MON_W | Interrupt mask, monitor flags |
| rd_stb | input | 1 | One-cycle read request |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Captured byte, valid the clock after the strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that condition, mask and read inputs are synchronous to `clk`, and that `rd_addr` is valid whenever `rd_stb` is high. They also assume a condition high for one edge counts as an event. The bench changes every input on the falling edge and holds each read strobe for exactly one rising edge, so all inputs stay inside these assumptions. Condition pulses are kept apart from reads, except in the directed re-latch test, which holds a condition high across a read on purpose.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam logic [7:0] ADDR_STAT = 8'd2;
  localparam logic [7:0] ADDR_LOS  = 8'd3;
  localparam logic [7:0] ADDR_FLT  = 8'd4;
  localparam logic [7:0] ADDR_MON  = 8'd5;
  localparam int BIT_DNR  = 0;
  localparam int BIT_IRQ  = 1;
  localparam int BIT_DONE = 2;
endpackage

// File: rtl/stat_flag_bank.sv
module stat_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         clr,
  output logic [W-1:0] flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= cond | (flag & ~{W{clr}});
  end

  // R1 R4
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond) |=> ((flag & $past(cond)) == $past(cond)));
  // R1
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flag & $past(flag)) == $past(flag)));
endmodule

// File: rtl/stat_init_seq.sv
module stat_init_seq #(
  parameter int INIT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_done,
  output logic dnr,
  output logic done_flag
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = dnr && (cnt == CW'(INIT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      dnr       <= 1'b1;
      done_flag <= 1'b0;
    end else begin
      if (dnr && !hit) cnt <= cnt + 1'b1;
      if (hit) dnr <= 1'b0;
      done_flag <= hit | (done_flag & ~clr_done);
    end
  end

  // R8
  dnr_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dnr |=> !dnr);
  // R8
  done_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dnr) |-> done_flag);
endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  input  logic         dnr,
  input  logic         done_flag,
  output logic         irq_n
);
  logic want;
  assign want = !dnr && ((|(flags & ~mask)) || done_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~want;
  end

  // R8
  irq_held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dnr |=> irq_n);
  // R5 R6
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_flag && ((flags & ~mask) == '0)) |=> irq_n);
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int MON_W       = 8,
  parameter int INIT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] rx_los_cond,
  input  logic [LANES-1:0] tx_los_cond,
  input  logic [LANES-1:0] tx_flt_cond,
  input  logic [MON_W-1:0] mon_cond,
  input  logic [LANES-1:0] rx_los_mask,
  input  logic [LANES-1:0] tx_los_mask,
  input  logic [LANES-1:0] tx_flt_mask,
  input  logic [MON_W-1:0] mon_mask,
  input  logic             rd_stb,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             irq_n
);
  localparam int TOT = 3 * LANES + MON_W;

  logic clr_stat, clr_los, clr_flt, clr_mon;
  logic [LANES-1:0] rx_flag, tx_flag, flt_flag;
  logic [MON_W-1:0] mon_flag;
  logic dnr, done_flag;
  logic [7:0] b_stat, b_los, b_flt, b_mon, rd_next;

  assign clr_stat = rd_stb && (rd_addr == ADDR_STAT);
  assign clr_los  = rd_stb && (rd_addr == ADDR_LOS);
  assign clr_flt  = rd_stb && (rd_addr == ADDR_FLT);
  assign clr_mon  = rd_stb && (rd_addr == ADDR_MON);

  stat_flag_bank #(.W(LANES)) u_rx  (.clk(clk), .rst_n(rst_n), .cond(rx_los_cond),
                                     .clr(clr_los), .flag(rx_flag));
  stat_flag_bank #(.W(LANES)) u_tx  (.clk(clk), .rst_n(rst_n), .cond(tx_los_cond),
                                     .clr(clr_los), .flag(tx_flag));
  stat_flag_bank #(.W(LANES)) u_flt (.clk(clk), .rst_n(rst_n), .cond(tx_flt_cond),
                                     .clr(clr_flt), .flag(flt_flag));
  stat_flag_bank #(.W(MON_W)) u_mon (.clk(clk), .rst_n(rst_n), .cond(mon_cond),
                                     .clr(clr_mon), .flag(mon_flag));

  stat_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .clr_done(clr_stat), .dnr(dnr), .done_flag(done_flag));

  stat_irq_merge #(.W(TOT)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .flags({mon_flag, flt_flag, tx_flag, rx_flag}),
    .mask({mon_mask, tx_flt_mask, tx_los_mask, rx_los_mask}),
    .dnr(dnr), .done_flag(done_flag), .irq_n(irq_n));

  always_comb begin
    b_stat = '0;
    b_stat[BIT_DNR]  = dnr;
    b_stat[BIT_IRQ]  = irq_n;
    b_stat[BIT_DONE] = done_flag;
    b_los = '0;
    b_los[2*LANES-1:0] = {tx_flag, rx_flag};
    b_flt = '0;
    b_flt[LANES-1:0] = flt_flag;
    b_mon = '0;
    b_mon[MON_W-1:0] = mon_flag;
    case (rd_addr)
      ADDR_STAT: rd_next = b_stat;
      ADDR_LOS:  rd_next = b_los;
      ADDR_FLT:  rd_next = b_flt;
      ADDR_MON:  rd_next = b_mon;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_next;
  end

  // R3
  flt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flt && !(|tx_flt_cond)) |=> (flt_flag == '0));
  // R3
  mon_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_los |=> ((mon_flag & $past(mon_flag)) == $past(mon_flag)));
endmodule

// File: tb/stat_irq_ctrl_tb.sv
module stat_irq_ctrl_tb;
  localparam int INIT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] rxc = '0, txc = '0, flc = '0, mrx = '0, mtx = '0, mfl = '0;
  logic [7:0] monc = '0, mmon = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_n;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stat_irq_ctrl #(.LANES(4), .MON_W(8), .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_los_cond(rxc), .tx_los_cond(txc), .tx_flt_cond(flc), .mon_cond(monc),
    .rx_los_mask(mrx), .tx_los_mask(mtx), .tx_flt_mask(mfl), .mon_mask(mmon),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

  typedef struct packed {
    logic [3:0] rx, tx, fl;
    logic [7:0] mon;
    logic [3:0] mrx, mtx, mfl;
    logic [7:0] mmon, addr, exp;
    logic       eirq;
  } vec_t;

  // fields: rx tx fl mon | mrx mtx mfl mmon | addr exp irq_n
  localparam vec_t VECS [10] = '{
    '{4'h1, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 8'd3, 8'h01, 1'b0},
    '{4'h0, 4'h8, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 8'd3, 8'h80, 1'b0},
    '{4'h0, 4'h0, 4'h6, 8'h00, 4'h0, 4'h0, 4'h6, 8'h00, 8'd4, 8'h06, 1'b1},
    '{4'h0, 4'h0, 4'h0, 8'h81, 4'h0, 4'h0, 4'h0, 8'h01, 8'd5, 8'h81, 1'b0},
    '{4'hF, 4'h0, 4'h0, 8'h00, 4'hF, 4'h0, 4'h0, 8'h00, 8'd3, 8'h0F, 1'b1},
    '{4'h0, 4'h0, 4'h9, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 8'd4, 8'h09, 1'b0},
    '{4'h0, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 8'd6, 8'h00, 1'b1},
    '{4'h2, 4'h1, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 8'd3, 8'h12, 1'b0},
    '{4'h4, 4'h0, 4'h0, 8'h00, 4'h4, 4'h0, 4'h0, 8'h00, 8'd2, 8'h02, 1'b1},
    '{4'h4, 4'h0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 8'h00, 8'd2, 8'h00, 1'b0}
  };

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] r, input logic [3:0] t,
                       input logic [3:0] f, input logic [7:0] m);
    @(negedge clk); rxc = r; txc = t; flc = f; monc = m;
    @(negedge clk); rxc = '0; txc = '0; flc = '0; monc = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    idle(3);
    check("R9 irq_n in reset", {7'b0, irq_n}, 8'h01);
    check("R9 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    idle(1);
    check("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);
    rd(8'd2, d);
    check("R7 status byte while not ready", d, 8'h03);
    pulse(4'h1, 4'h0, 4'h0, 8'h00);
    idle(3);
    check("R8 irq held off while not ready", {7'b0, irq_n}, 8'h01);
    idle(INIT + 5);
    check("R8 irq after init completes", {7'b0, irq_n}, 8'h00);
    rd(8'd2, d);
    check("R7 R8 status byte done posted", d, 8'h04);
    rd(8'd3, d);
    check("R1 flag latched during not-ready", d, 8'h01);
    idle(2);
    check("R6 irq released after clear", {7'b0, irq_n}, 8'h01);
    rd(8'd2, d);
    check("R7 done flag cleared by read", d, 8'h02);

    foreach (VECS[i]) begin
      mrx = VECS[i].mrx; mtx = VECS[i].mtx; mfl = VECS[i].mfl; mmon = VECS[i].mmon;
      pulse(VECS[i].rx, VECS[i].tx, VECS[i].fl, VECS[i].mon);
      idle(3);
      check($sformatf("R5 R6 vec%0d irq_n", i), {7'b0, irq_n}, {7'b0, VECS[i].eirq});
      rd(VECS[i].addr, d);
      check($sformatf("R1 R2 R3 vec%0d byte", i), d, VECS[i].exp);
      rd(8'd3, d); rd(8'd4, d); rd(8'd5, d);
      idle(2);
      check($sformatf("R6 vec%0d irq_n after clear", i), {7'b0, irq_n}, 8'h01);
      rd(VECS[i].addr == 8'd2 ? 8'd3 : VECS[i].addr, d);
      check($sformatf("R3 vec%0d byte cleared", i), d, 8'h00);
    end
    mrx = '0; mtx = '0; mfl = '0; mmon = '0;

    // R3: clearing one byte leaves another byte intact
    pulse(4'h3, 4'h0, 4'h0, 8'h40);
    rd(8'd3, d);
    check("R3 LOS byte", d, 8'h03);
    rd(8'd5, d);
    check("R3 monitor byte not cleared by LOS read", d, 8'h40);

    // R4: condition held across the clearing read
    @(negedge clk); rxc = 4'h1;
    idle(2);
    rd(8'd3, d);
    check("R4 first read", d, 8'h01);
    rd(8'd3, d);
    check("R4 re-latched while held", d, 8'h01);
    rxc = '0;
    rd(8'd3, d);
    check("R4 still set after release", d, 8'h01);
    rd(8'd3, d);
    check("R4 cleared after release", d, 8'h00);

    // R1: short pulse survives a long wait
    pulse(4'h0, 4'h0, 4'h8, 8'h00);
    idle(40);
    rd(8'd4, d);
    check("R1 one-cycle fault kept", d, 8'h08);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule